// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital side of a dual-slope integrating voltmeter. A start pulse begins a conversion with the integrator tied to the unknown input. A decimal counter then times a fixed integrate interval. The counter advances only while the zero-detect comparator reports that the integrator output has left zero. When the counter wraps from its all-nines value back to zero, the block moves the integrator onto the opposite-polarity reference. The same counter, now starting from zero, measures the de-integrate interval.

The de-integrate interval ends when the comparator reports that the integrator is back at zero. The count at that moment is proportional to the input. It is latched as a BCD reading and announced with a one-cycle strobe. If the integrator has not returned to zero before the counter would wrap a second time, the conversion ends anyway with an overrange flag. The comparator is asynchronous to the clock, so it passes through a synchronizer before any decision is made on it.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, `sel_input` is 1, `sel_ref` is 0, and `done`, `overrange` and `result` are all 0.
- R2: A `start` pulse clears the counter and `overrange` from any state, selects the input switch, deselects the reference switch, and begins a full-length integrate interval. This holds in idle and also partway through a conversion.
- R3: The counter advances on a clock edge only if the synchronized comparator is 1. The comparator reaches the control logic after two register stages, and each cycle the comparator is held at 0 during integrate lengthens that interval by one cycle.
- R4: The integrate interval lasts exactly 10000 counted cycles. On the edge that takes the count from 9999 to 0000, `sel_input` falls and `sel_ref` rises. The two switch selects are never 1 together.
- R5: In de-integrate, counting restarts from 0000. On the first edge that sees the synchronized comparator at 0, `result` is loaded with the count and `overrange` is 0. Digit k of `result` occupies bits 4k+3..4k, digit 0 is the least significant decade, and each digit is a BCD value from 0 to 9.
- R6: `done` is high for exactly one cycle, on the cycle the reading is loaded. `result` changes only on that cycle. After the end of a conversion both switch selects are 0.
- R7: If the count in de-integrate is 9999 and the synchronized comparator is still 1, the next edge ends the conversion with `result` = 9999, `overrange` = 1 and `done` = 1.
- R8: If `start` arrives on the same edge that would end de-integrate, the start takes priority. No `done` is produced, and a new integrate interval begins with the input selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the counting oscillator |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a conversion |
| cmp_raw | input | 1 | Asynchronous zero-detect comparator, 1 while the integrator is away from zero |
| sel_input | output | 1 | Closes the switch from the unknown input to the integrator |
| sel_ref | output | 1 | Closes the switch from the opposite-polarity reference to the integrator |
| result | output | 16 | Latched BCD reading, four decades |
| overrange | output | 1 | Set when the last conversion hit the de-integrate limit |
| done | output | 1 | One-cycle strobe when a reading is latched |

## Verification
Two functions can coincide on one clock edge. A new `start` can arrive on the same edge where the return-to-zero would end de-integrate. The bench provokes this by lowering the comparator and then raising `start` exactly two cycles later, so the start lands on the edge where the synchronized zero would be taken. The outcome is judged by three observations: no `done` strobe appears, the input switch is selected again, and the following integrate interval has full length. A second boundary is also covered: a return to zero that lands on the count of 9999, compared with one that comes a cycle later. The first must yield a normal 9999 reading and the second an overrange.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  localparam int          DIGIT_W   = 4;
  localparam logic [3:0]  DIGIT_TOP = 4'd9;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter
  import dsc_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGIT_W * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] at_nine;

  assign carry[0] = inc;

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
      logic [DIGIT_W-1:0] dig;

      always_ff @(posedge clk) begin
        if (rst || clr)    dig <= '0;
        else if (carry[g]) dig <= at_nine[g] ? '0 : dig + 4'd1;
      end

      assign at_nine[g]             = (dig == DIGIT_TOP);
      assign carry[g+1]             = carry[g] & at_nine[g];
      assign value[g*DIGIT_W +: DIGIT_W] = dig;
    end
  endgenerate

  // full-scale rollover: the increment ripples out of the top decade
  assign wrap = carry[DIGITS];
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_s,
  input  logic [RES_W-1:0] cnt_val,
  input  logic             cnt_wrap,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             sel_input,
  output logic             sel_ref,
  output logic             done,
  output logic             overrange,
  output logic [RES_W-1:0] result
);
  phase_e st;

  assign cnt_clr = start;
  assign cnt_inc = !start && cmp_s && (st != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      sel_input <= 1'b1;
      sel_ref   <= 1'b0;
      done      <= 1'b0;
      overrange <= 1'b0;
      result    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st        <= PH_INTEG;
        sel_input <= 1'b1;
        sel_ref   <= 1'b0;
        overrange <= 1'b0;
      end else begin
        case (st)
          PH_INTEG: begin
            if (cnt_wrap) begin
              st        <= PH_DEINT;
              sel_input <= 1'b0;
              sel_ref   <= 1'b1;
            end
          end
          PH_DEINT: begin
            if (!cmp_s || cnt_wrap) begin
              st        <= PH_IDLE;
              sel_ref   <= 1'b0;
              done      <= 1'b1;
              result    <= cnt_val;
              overrange <= cnt_wrap;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = DIGIT_W * DIGITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_raw,
  output logic             sel_input,
  output logic             sel_ref,
  output logic [RES_W-1:0] result,
  output logic             overrange,
  output logic             done
);
  logic             cmp_s;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             cnt_wrap;
  logic [RES_W-1:0] cnt_val;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_raw),
    .q   (cmp_s)
  );

  dsc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .value (cnt_val),
    .wrap  (cnt_wrap)
  );

  dsc_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmp_s     (cmp_s),
    .cnt_val   (cnt_val),
    .cnt_wrap  (cnt_wrap),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .sel_input (sel_input),
    .sel_ref   (sel_ref),
    .done      (done),
    .overrange (overrange),
    .result    (result)
  );
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sel_input,
  input logic             sel_ref,
  input logic             done,
  input logic             overrange,
  input logic [RES_W-1:0] result
);
  // R4
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_input && sel_ref));

  // R4
  ref_handover_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ref) |-> ($fell(sel_input) && !done));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (sel_input && !sel_ref && !done && !overrange));

  // R7
  ovr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrange) |-> done);

  // R5
  ref_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sel_ref) && !$past(start)) |-> done);
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sel_input (sel_input),
  .sel_ref   (sel_ref),
  .done      (done),
  .overrange (overrange),
  .result    (result)
);

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
  localparam int DIGITS = 4;
  localparam int RES_W  = 4 * DIGITS;
  localparam int SPAN   = 10000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             cmp_raw = 1'b0;
  logic             sel_input, sel_ref, overrange, done;
  logic [RES_W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_slope_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .cmp_raw(cmp_raw),
    .sel_input(sel_input), .sel_ref(sel_ref), .result(result),
    .overrange(overrange), .done(done)
  );

  function automatic logic [RES_W-1:0] to_bcd(input int v);
    logic [RES_W-1:0] r;
    int x;
    x = v;
    for (int k = 0; k < DIGITS; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic begin_conv();
    @(negedge clk);
    start   = 1'b1;
    cmp_raw = 1'b1;
  endtask

  // integrate interval; exp_n = negedges from the start edge until sel_ref is seen
  task automatic integ_phase(input int gap_at, input int gap_len,
                             input int exp_n, input string tag);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (n == 1) begin
        chk({tag, " no strobe after start"}, int'(done), 0);
        chk({tag, " input selected"}, int'({sel_input, sel_ref}), 2);
        chk("R2 overrange cleared", int'(overrange), 0);
      end
      if (n == gap_at)           cmp_raw = 1'b0;
      if (n == gap_at + gap_len) cmp_raw = 1'b1;
    end while (!sel_ref && n < 3 * SPAN);
    chk("R3 gated integrate length", n, exp_n);
    chk("R4 input released at handover", int'(sel_input), 0);
  endtask

  task automatic deint_phase(input int t, input bit collide);
    logic [RES_W-1:0] held;
    repeat (t) @(negedge clk);
    cmp_raw = 1'b0;
    if (collide) begin
      repeat (2) @(negedge clk);
      start   = 1'b1;
      cmp_raw = 1'b1;
    end else begin
      repeat (3) @(negedge clk);
      chk("R6 strobe on reading", int'(done), 1);
      chk("R5 reading", int'(result), int'(to_bcd(t + 2)));
      chk("R5 no overrange", int'(overrange), 0);
      chk("R6 switches open", int'({sel_input, sel_ref}), 0);
      held = result;
      @(negedge clk);
      chk("R6 strobe single cycle", int'(done), 0);
      repeat (16) @(negedge clk);
      chk("R6 reading held", int'(result), int'(held));
    end
  endtask

  task automatic ovr_phase();
    int m;
    m = 0;
    do begin
      @(negedge clk);
      m++;
    end while (!done && m < SPAN + 10);
    chk("R7 limit cycle", m, SPAN);
    chk("R7 reading at limit", int'(result), int'(to_bcd(SPAN - 1)));
    chk("R7 overrange set", int'(overrange), 1);
    chk("R6 reference released", int'(sel_ref), 0);
    cmp_raw = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 overrange held", int'(overrange), 1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int t;
    int g;
    int ga;
    t = int'($urandom(32'd4242));
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 reset switches", int'({sel_input, sel_ref}), 2);
    chk("R1 reset strobe", int'(done), 0);
    chk("R1 reset reading", int'(result), 0);
    chk("R1 reset overrange", int'(overrange), 0);
    repeat (4) @(negedge clk);

    // comparator gap during integrate, reading with carries (1234)
    begin_conv();
    integ_phase(100, 5, SPAN + 2 + 5, "R2");
    deint_phase(1232, 1'b0);

    // R2 restart partway through integrate, then shortest reading
    begin_conv();
    repeat (300) begin
      @(negedge clk);
      start = 1'b0;
    end
    start = 1'b1;
    integ_phase(-1, 0, SPAN + 1, "R2");
    deint_phase(0, 1'b0);

    // return to zero exactly at 9999: a normal reading
    begin_conv();
    integ_phase(-1, 0, SPAN + 2, "R2");
    deint_phase(SPAN - 3, 1'b0);

    // R7 comparator never returns
    begin_conv();
    integ_phase(-1, 0, SPAN + 2, "R2");
    ovr_phase();

    // flag cleared by the next start, decade carry reading 10
    begin_conv();
    integ_phase(-1, 0, SPAN + 2, "R2");
    deint_phase(8, 1'b0);

    // R8 start on the same edge as the return to zero
    begin_conv();
    integ_phase(-1, 0, SPAN + 2, "R2");
    deint_phase(50, 1'b1);
    integ_phase(-1, 0, SPAN + 2, "R8");
    deint_phase(98, 1'b0);

    // random readings with random comparator gaps
    for (int i = 0; i < 2; i++) begin
      t  = int'($urandom_range(0, SPAN - 3));
      g  = int'($urandom_range(0, 40));
      ga = int'($urandom_range(2, 9000));
      begin_conv();
      integ_phase(ga, g, SPAN + 2 + g, "R2");
      deint_phase(t, 1'b0);
    end

    summary();
    $finish;
  end
endmodule